// File: doc/BRIEF.md
# Dual-Mode Bus Ownership Arbiter

This block decides who owns a shared external bus on behalf of one on-chip master. The bus has three active-low handshake lines: request, grant and busy. Each line is brought out as a separate input, output value and output enable, so the pad ring builds the tri-state buffer. A mode input picks one of two roles. In the arbiter role the block drives grant to a single external master and keeps the bus for the local master whenever it asks first. In the requester role the block asks an outside arbiter with the request line. It takes the bus only on a qualified grant, meaning grant is asserted and busy is negated.

The local master uses a request/acknowledge/done handshake. It raises `loc_req` and holds it. It owns the bus while `loc_ack` is high, and it pulses `loc_done` to end its tenure. The block drives busy low during the tenure. It drives busy high for one cycle when the tenure ends, then lets the line float. The `park` input tells the block that the outside arbiter has parked the bus on this chip, so no request needs to be driven.

Top module: `bus_tenure_arbiter`

## Requirements
- R1: While reset is held and after it is released, `loc_ack` is 0, every bus output value is 1 (negated), the busy and grant enables are 0, the request enable is 1, and the block is in the requester role (mode 0).
- R2: Each bus input line passes through two flip-flops. A change on `breq_i`, `bgnt_i` or `bbusy_i` first affects the outputs after the third rising clock edge.
- R3: In the arbiter role (`arb_mode` = 1), `breq_oe` is 0. `bgnt_oe` is 1, and `bgnt_o` is 1 except while a grant is given.
- R4: In the arbiter role, an external request (`breq_i` low) is granted (`bgnt_o` low) only when the local master is neither requesting nor owning and the bus is not busy. When both requests arrive in the same cycle, the local master wins. The external request is served after the local tenure ends.
- R5: In the arbiter role, the grant is withdrawn once `bbusy_i` is seen low. The bus stays with the external master, and even a local request waits, until `bbusy_i` is seen high again.
- R6: In the arbiter role, a local request while the bus is free makes `loc_ack` 1, with `bbusy_o` = 0 and `bbusy_oe` = 1.
- R7: A `loc_done` pulse during ownership drops `loc_ack`. On the next cycle busy is driven high (`bbusy_o` = 1, `bbusy_oe` = 1) for exactly one cycle, and then `bbusy_oe` returns to 0.
- R8: In the requester role (`arb_mode` = 0), `bgnt_oe` is 0 and `breq_oe` is 1. While the local master waits for the bus, `breq_o` is 0 if `park` is 0 and stays 1 if `park` is 1.
- R9: In the requester role, the local master is acknowledged only after a qualified grant (`bgnt_i` low and `bbusy_i` high). A grant seen while busy is low is not enough.
- R10: A change of `arb_mode` takes effect only while the block is idle. A change made during a tenure takes effect after the tenure ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_mode | input | 1 | 1 = arbiter role, 0 = requester role |
| park | input | 1 | Bus is parked on this chip (requester role) |
| loc_req | input | 1 | Local master wants the bus |
| loc_done | input | 1 | One-cycle pulse ending the local tenure |
| loc_ack | output | 1 | Local master owns the bus |
| breq_i | input | 1 | Request line as seen on the pad, active low |
| breq_o | output | 1 | Request line value to drive |
| breq_oe | output | 1 | Request line drive enable |
| bgnt_i | input | 1 | Grant line as seen on the pad, active low |
| bgnt_o | output | 1 | Grant line value to drive |
| bgnt_oe | output | 1 | Grant line drive enable |
| bbusy_i | input | 1 | Busy line as seen on the pad, active low |
| bbusy_o | output | 1 | Busy line value to drive |
| bbusy_oe | output | 1 | Busy line drive enable |

## Verification
A change on a bus line reaches the outputs after three rising edges. A change of `loc_req` or `loc_done` reaches them after one edge, and a mode change needs one further edge while idle. The vector table holds each stimulus for five edges, which covers every such chain, before it compares the outputs. The directed tests sample at exact edge counts: before and after the third edge for the synchronizer, and one and two edges after `loc_done` for the one-cycle release.

// File: rtl/bus_tenure_arbiter.sv
module bus_tenure_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_mode,
  input  logic park,
  input  logic loc_req,
  input  logic loc_done,
  output logic loc_ack,
  input  logic breq_i,
  output logic breq_o,
  output logic breq_oe,
  input  logic bgnt_i,
  output logic bgnt_o,
  output logic bgnt_oe,
  input  logic bbusy_i,
  output logic bbusy_o,
  output logic bbusy_oe
);

  typedef enum logic [2:0] {S_IDLE, S_ASK, S_OWN, S_REL, S_GNT, S_EXT} st_t;

  st_t        st, nx;
  logic [2:0] sy1, sy2;
  logic       mode_q;
  logic       req_s, gnt_s, busy_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 3'b111;
      sy2 <= 3'b111;
    end else begin
      sy1 <= {breq_i, bgnt_i, bbusy_i};
      sy2 <= sy1;
    end

  assign req_s  = ~sy2[2];
  assign gnt_s  = ~sy2[1];
  assign busy_s = ~sy2[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             mode_q <= 1'b0;
    else if (st == S_IDLE)  mode_q <= arb_mode;

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:
        if (mode_q) begin
          if (!busy_s && loc_req)     nx = S_OWN;
          else if (!busy_s && req_s)  nx = S_GNT;
        end else if (loc_req)         nx = S_ASK;
      S_ASK:
        if (!loc_req)                 nx = S_IDLE;
        else if (gnt_s && !busy_s)    nx = S_OWN;
      S_OWN: if (loc_done)            nx = S_REL;
      S_REL:                          nx = S_IDLE;
      S_GNT:
        if (busy_s)                   nx = S_EXT;
        else if (!req_s)              nx = S_IDLE;
      S_EXT: if (!busy_s)             nx = S_IDLE;
      default:                        nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;

  assign loc_ack  = (st == S_OWN);
  assign breq_oe  = ~mode_q;
  assign breq_o   = ~((st == S_ASK) && !park);
  assign bgnt_oe  = mode_q;
  assign bgnt_o   = ~(st == S_GNT);
  assign bbusy_oe = (st == S_OWN) || (st == S_REL);
  assign bbusy_o  = ~(st == S_OWN);

  assert_grant_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_GNT) |-> $past(!busy_s && !loc_req && mode_q));

  assert_grant_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bgnt_oe && !bgnt_o, loc_ack}));

  assert_grant_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GNT && busy_s) |=> bgnt_o);

  assert_release_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_ack && loc_done) |=> (bbusy_oe && bbusy_o && !loc_ack));

  assert_release_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bbusy_oe && bbusy_o) |=> !bbusy_oe);

  assert_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(loc_ack) && !mode_q) |-> $past(gnt_s && !busy_s));

endmodule

// File: tb/bus_tenure_arbiter_test.sv
module bus_tenure_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_mode = 1'b0, park = 1'b0, loc_req = 1'b0, loc_done = 1'b0;
  logic breq_i = 1'b1, bgnt_i = 1'b1, bbusy_i = 1'b1;
  logic loc_ack, breq_o, breq_oe, bgnt_o, bgnt_oe, bbusy_o, bbusy_oe;
  logic [6:0] obs;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_tenure_arbiter uut (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .park(park),
    .loc_req(loc_req), .loc_done(loc_done), .loc_ack(loc_ack),
    .breq_i(breq_i), .breq_o(breq_o), .breq_oe(breq_oe),
    .bgnt_i(bgnt_i), .bgnt_o(bgnt_o), .bgnt_oe(bgnt_oe),
    .bbusy_i(bbusy_i), .bbusy_o(bbusy_o), .bbusy_oe(bbusy_oe));

  assign obs = {loc_ack, breq_o, breq_oe, bgnt_o, bgnt_oe, bbusy_o, bbusy_oe};

  // stim {mode,park,lreq,done,breq_n,bgnt_n,bbusy_n} ; exp {ack,breq_o,breq_oe,bgnt_o,bgnt_oe,bbusy_o,bbusy_oe}
  localparam logic [13:0] VEC [16] = '{
    {7'b1000111, 7'b0101110},
    {7'b1010111, 7'b1101101},
    {7'b1001111, 7'b0101110},
    {7'b1000011, 7'b0100110},
    {7'b1000010, 7'b0101110},
    {7'b1010010, 7'b0101110},
    {7'b1010111, 7'b1101101},
    {7'b1001111, 7'b0101110},
    {7'b0000111, 7'b0111010},
    {7'b0010111, 7'b0011010},
    {7'b0010100, 7'b0011010},
    {7'b0010101, 7'b1111001},
    {7'b0001111, 7'b0111010},
    {7'b0110111, 7'b0111010},
    {7'b0110101, 7'b1111001},
    {7'b0001111, 7'b0111010}
  };

  function automatic string vtag(int i);
    case (i)
      0:  return "R3";
      1:  return "R6";
      2:  return "R7";
      3:  return "R4";
      4:  return "R5";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R8";
      10: return "R9";
      11: return "R9";
      12: return "R7";
      13: return "R8";
      14: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1;
    chk("R1", obs, 7'b0111010);
    edges(2);
    rst_n = 1'b1;
    edges(2);
    chk("R1", obs, 7'b0111010);

    for (int i = 0; i < 16; i++) begin
      {arb_mode, park, loc_req, loc_done, breq_i, bgnt_i, bbusy_i} = VEC[i][13:7];
      edges(5);
      chk(vtag(i), obs, VEC[i][6:0]);
    end

    // R2: synchronizer latency
    arb_mode = 1'b1; loc_done = 1'b0;
    edges(5);
    breq_i = 1'b0;
    edges(2);
    chk("R2", {7'b0, bgnt_o}, 7'd1);
    edges(1);
    chk("R2", {7'b0, bgnt_o}, 7'd0);
    bbusy_i = 1'b0; edges(5);
    breq_i = 1'b1; bbusy_i = 1'b1; edges(5);

    // R4: tie goes to local master, external served afterwards
    loc_req = 1'b1; breq_i = 1'b0;
    edges(5);
    chk("R4", {5'b0, loc_ack, bgnt_o}, 7'b0000011);
    loc_req = 1'b0; loc_done = 1'b1;
    edges(1);
    chk("R7", {4'b0, loc_ack, bbusy_o, bbusy_oe}, 7'b0000011);
    loc_done = 1'b0;
    edges(1);
    chk("R7", {6'b0, bbusy_oe}, 7'd0);
    edges(1);
    chk("R4", {6'b0, bgnt_o}, 7'd0);
    breq_i = 1'b1;
    edges(5);

    // R10: mode change during a tenure is deferred
    loc_req = 1'b1; edges(3);
    arb_mode = 1'b0; edges(4);
    chk("R10", {4'b0, loc_ack, breq_oe, bgnt_oe}, 7'b0000101);
    loc_req = 1'b0; loc_done = 1'b1; edges(1);
    loc_done = 1'b0; edges(5);
    chk("R10", {5'b0, breq_oe, bgnt_oe}, 7'b0000010);

    // R1: reset during a pending request
    loc_req = 1'b1; edges(3);
    rst_n = 1'b0; #1;
    chk("R1", obs, 7'b0111010);
    loc_req = 1'b0;
    edges(1);
    rst_n = 1'b1;
    edges(2);
    chk("R1", obs, 7'b0111010);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule